// File: doc/BRIEF.md
# SEC-DED Codeword Corrector

This block protects 32-bit words with seven check bits. The code's parity-check columns all have odd weight. The block has two parts that run side by side. The first is a combinational encoder. It turns a data word into a 39-bit codeword. The second is a decoder that registers its result. It takes a received codeword and returns the repaired data word with two status flags. A system places the encoder on the path that writes to storage and the decoder on the path that reads from it.

The decoder has three stages, each in its own module:

1. **Syndrome stage.** It folds the whole received codeword, data and check bits together, through the fixed parity-check matrix.
2. **Flip stage.** It looks only at the syndrome. It produces a mask of the codeword bits to invert.
3. **Classification stage.** It reads the syndrome and the mask. It reports whether any error was seen and whether that error could not be repaired.

Because the classification stage is separate, it can be replaced without touching the correction datapath. The repaired word, the flags and a valid strobe are captured in one register stage.

Top module: `hsiao_corrector`

## Requirements
- R1: Codeword layout and matrix. Bits [31:0] carry the data and bits [38:32] carry the check bits.
  - Check bit k (codeword bit 32+k) has the one-hot column with only bit k set.
  - Data bit j has as its column the j-th smallest 7-bit value with exactly three ones, counting from j=0 in ascending numeric order.
- R2: A received codeword whose syndrome is zero is returned with its data unchanged, with `out_err` and `out_uncorr` both low.
- R3: A codeword with exactly one flipped data bit is returned with the original data restored, `out_err` high and `out_uncorr` low.
- R4: A codeword with exactly one flipped check bit is returned with its data unchanged, `out_err` high and `out_uncorr` low.
- R5: A codeword with any two flipped bits is reported with `out_err` and `out_uncorr` high. The received data is returned unmodified.
- R6: An odd-weight nonzero syndrome that equals no column causes the same uncorrectable report with the data unmodified. Examples are a weight-three value that no data bit uses, a weight-five value and the all-ones value.
- R7: Timing and reset.
  - A codeword presented with `in_valid` high in one cycle gives its result, with `out_valid` high, in the next cycle.
  - `out_valid` is low in any cycle after one without `in_valid`.
  - Synchronous reset `rst` clears every output register to zero.
- R8: `out_uncorr` is never high while `out_err` is low.
- R9: `enc_code` is, within the same cycle, `enc_data` in bits [31:0] and check bits in [38:32] such that the syndrome of the codeword is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data | input | 32 | Data word to encode |
| enc_code | output | 39 | Encoded codeword (combinational) |
| in_valid | input | 1 | Received codeword is present |
| rx_code | input | 39 | Received codeword to decode |
| out_valid | output | 1 | Decoded result is present |
| out_data | output | 32 | Repaired data word |
| out_err | output | 1 | An error was seen |
| out_uncorr | output | 1 | The error could not be repaired |

## Verification
Encoding and decoding share each cycle. The bench therefore drives a fresh random word into the encoder in every cycle in which it also sends a codeword to the decoder. It compares the encoder output against its own matrix before the clock edge, while the decoder result of the previous codeword is checked at the same falling edge. Codewords are sent back to back with no idle cycles. This shows that one result register never mixes two consecutive codewords. Each expected result comes from the injected fault pattern itself, not from a syndrome.

// File: rtl/hsiao_pkg.sv
package hsiao_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int COL_WT = 3;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CHK_W-1:0]  syn_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic detected;
        logic fatal;
    } flags_t;

    typedef struct packed {
        word_t  data;
        flags_t flags;
    } result_t;

    // Column of the parity-check matrix for codeword bit idx.
    function automatic syn_t column(input int idx);
        syn_t found;
        int   seen;
        found = '0;
        seen  = 0;
        if (idx >= DATA_W) begin
            found = syn_t'(1) << (idx - DATA_W);
        end else begin
            for (int v = 0; v < (1 << CHK_W); v++) begin
                if ($countones(syn_t'(v)) == COL_WT) begin
                    if (seen == idx) found = syn_t'(v);
                    seen++;
                end
            end
        end
        return found;
    endfunction

    // Row r of the matrix over the whole codeword.
    function automatic code_t code_row(input int r);
        code_t m;
        syn_t  c;
        m = '0;
        for (int i = 0; i < CODE_W; i++) begin
            c    = column(i);
            m[i] = c[r];
        end
        return m;
    endfunction

    // Row r restricted to the data bits.
    function automatic word_t data_row(input int r);
        code_t m;
        m = code_row(r);
        return m[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/hsiao_encoder.sv
module hsiao_encoder
    import hsiao_pkg::*;
(
    input  word_t data,
    output code_t code
);
    syn_t chk;

    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam word_t MASK = data_row(r);
        assign chk[r] = ^(data & MASK);
    end

    assign code = {chk, data};
endmodule

// File: rtl/hsiao_syndrome.sv
module hsiao_syndrome
    import hsiao_pkg::*;
(
    input  code_t code,
    output syn_t  syn
);
    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam code_t MASK = code_row(r);
        assign syn[r] = ^(code & MASK);
    end
endmodule

// File: rtl/hsiao_flipcalc.sv
module hsiao_flipcalc
    import hsiao_pkg::*;
(
    input  syn_t  syn,
    output code_t flip
);
    // Odd-weight columns never equal an even syndrome, so such syndromes
    // and unmatched ones both leave the mask empty.
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        localparam syn_t COL = column(i);
        assign flip[i] = (syn == COL);
    end
endmodule

// File: rtl/hsiao_classify.sv
module hsiao_classify
    import hsiao_pkg::*;
(
    input  syn_t   syn,
    input  code_t  flip,
    output flags_t flags
);
    always_comb begin
        flags.detected = |syn;
        flags.fatal    = (|syn) & ~(|flip);
    end
endmodule

// File: rtl/hsiao_corrector.sv
module hsiao_corrector
    import hsiao_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data,
    output logic [CODE_W-1:0] enc_code,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] rx_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err,
    output logic              out_uncorr
);
    syn_t    syn;
    code_t   flip;
    flags_t  flags;
    result_t res_d, res_q;
    logic    vld_q;

    hsiao_encoder u_enc (.data(enc_data), .code(enc_code));
    hsiao_syndrome u_syn (.code(rx_code), .syn(syn));
    hsiao_flipcalc u_flip (.syn(syn), .flip(flip));
    hsiao_classify u_cls (.syn(syn), .flip(flip), .flags(flags));

    always_comb begin
        res_d.data  = rx_code[DATA_W-1:0] ^ flip[DATA_W-1:0];
        res_d.flags = flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_valid  = vld_q;
    assign out_data   = res_q.data;
    assign out_err    = res_q.flags.detected;
    assign out_uncorr = res_q.flags.fatal;
endmodule

// File: rtl/hsiao_corrector_chk.sv
module hsiao_corrector_chk
    import hsiao_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [CODE_W-1:0] rx_code,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_err,
    input logic              out_uncorr
);
    // R7
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    fatal_implies_det_chk: assert property (@(posedge clk) disable iff (rst)
        out_uncorr |-> out_err);

    // R2
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_err || out_data == $past(rx_code[DATA_W-1:0])));

    // R5
    raw_on_fatal_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_uncorr || out_data == $past(rx_code[DATA_W-1:0])));

    // R3
    one_flip_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ($countones(out_data ^ $past(rx_code[DATA_W-1:0])) <= 1));
endmodule

bind hsiao_corrector hsiao_corrector_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rx_code(rx_code),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err),
    .out_uncorr(out_uncorr)
);

// File: tb/hsiao_corrector_test.sv
`timescale 1ns/1ps
module hsiao_corrector_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] enc_data = '0;
    logic [38:0] enc_code;
    logic        in_valid = 1'b0;
    logic [38:0] rx_code = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_err;
    logic        out_uncorr;

    always #4 clk = ~clk;

    hsiao_corrector uut (
        .clk(clk), .rst(rst), .enc_data(enc_data), .enc_code(enc_code),
        .in_valid(in_valid), .rx_code(rx_code), .out_valid(out_valid),
        .out_data(out_data), .out_err(out_err), .out_uncorr(out_uncorr)
    );

    typedef struct {
        logic [31:0] d;
        logic        e;
        logic        u;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          tests = 0;
    int          fails = 0;
    logic [6:0]  hcol[39];
    logic [6:0]  spare[$];

    // Matrix built from R1.
    initial begin
        int n;
        n = 0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(7'(v)) == 3) begin
                if (n < 32) hcol[n] = 7'(v);
                else spare.push_back(7'(v));
                n++;
            end
        end
        for (int k = 0; k < 7; k++) hcol[32+k] = 7'(1 << k);
    end

    function automatic logic [38:0] mk(input logic [31:0] d);
        logic [6:0] c;
        c = '0;
        for (int j = 0; j < 32; j++) if (d[j]) c ^= hcol[j];
        return {c, d};
    endfunction

    task automatic send(input logic [38:0] code, input logic [31:0] d,
                        input logic e, input logic u, input string tag);
        logic [31:0] ed;
        exp_t        x;
        @(negedge clk);
        ed       = $urandom;
        enc_data = ed;
        in_valid = 1'b1;
        rx_code  = code;
        x.d = d; x.e = e; x.u = u; x.tag = tag;
        sb.push_back(x);
        #1;
        tests++;
        if (enc_code !== mk(ed)) begin
            fails++;
            $display("FAIL R9 enc_code actual %h expected %h", enc_code, mk(ed));
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t x;
            tests++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R7 out_valid with nothing pending actual 1 expected 0");
            end else begin
                x = sb.pop_front();
                if (out_data !== x.d || out_err !== x.e || out_uncorr !== x.u) begin
                    fails++;
                    $display("FAIL %s actual data=%h err=%b unc=%b expected data=%h err=%b unc=%b",
                             x.tag, out_data, out_err, out_uncorr, x.d, x.e, x.u);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [38:0] c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tests++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_err !== 1'b0 || out_uncorr !== 1'b0) begin
            fails++;
            $display("FAIL R7 reset actual v=%b d=%h e=%b u=%b expected all zero",
                     out_valid, out_data, out_err, out_uncorr);
        end

        // R2 clean words
        send(mk(32'h0), 32'h0, 1'b0, 1'b0, "R2 zero");
        send(mk(32'hFFFF_FFFF), 32'hFFFF_FFFF, 1'b0, 1'b0, "R2 ones");
        send(mk(32'hA5A5_5A5A), 32'hA5A5_5A5A, 1'b0, 1'b0, "R2 pattern");
        for (int i = 0; i < 8; i++) begin
            d = $urandom;
            send(mk(d), d, 1'b0, 1'b0, "R2 random");
        end

        // R3 single data-bit flips
        for (int j = 0; j < 32; j++) begin
            d = $urandom;
            c = mk(d);
            c[j] = ~c[j];
            send(c, d, 1'b1, 1'b0, "R3 data flip");
        end

        // R4 single check-bit flips
        for (int k = 0; k < 7; k++) begin
            d = $urandom;
            c = mk(d);
            c[32+k] = ~c[32+k];
            send(c, d, 1'b1, 1'b0, "R4 check flip");
        end

        // R5 double flips, adjacent and spread
        for (int i = 0; i < 39; i++) begin
            d = $urandom;
            c = mk(d);
            c[i] = ~c[i];
            c[(i + 1) % 39] = ~c[(i + 1) % 39];
            send(c, c[31:0], 1'b1, 1'b1, "R5 R8 double adj");
            c = mk(d);
            c[i] = ~c[i];
            c[(i + 17) % 39] = ~c[(i + 17) % 39];
            send(c, c[31:0], 1'b1, 1'b1, "R5 R8 double far");
        end

        // R6 odd-weight syndromes that match no column
        foreach (spare[s]) begin
            d = $urandom;
            c = mk(d);
            c[38:32] ^= spare[s];
            send(c, c[31:0], 1'b1, 1'b1, "R6 unused weight3");
        end
        d = $urandom;
        c = mk(d);
        c[38:32] ^= 7'b001_1111;
        send(c, c[31:0], 1'b1, 1'b1, "R6 weight5");
        d = $urandom;
        c = mk(d);
        c[38:32] ^= 7'h7F;
        send(c, c[31:0], 1'b1, 1'b1, "R6 weight7");

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || sb.size() != 0) begin
            fails++;
            $display("FAIL R7 idle actual v=%b pending=%0d expected v=0 pending=0",
                     out_valid, sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule